// File: doc/BRIEF.md
# Data Cache Set Integrity Scanner

This block examines one set of a four-way data cache after a cache error. Once started, it reads each way's tag and checks it. The check confirms that the 5-bit coherence state holds one of the permitted codes. For a permitted state, it also confirms the two parity bits that cover the physical tag.

When data checking is requested, the block also reads the four 64-bit doublewords of each way, together with their stored 8-bit check codes. It recomputes a 72/64 Hamming code for each doubleword and compares the two. It then grades every mismatch as a single-bit or multi-bit error, based on how many syndrome bits are set.

The arrays sit outside the block. They answer a read request combinationally in the same cycle, and the scanner samples the answer at the next rising edge. The results are an accumulated 32-bit error word, a 16-bit map of the doublewords that failed, and the LRU byte captured from way 0. A `done` level marks a finished scan.

Top module: `dcache_set_scrub`

## Requirements
- R1: A high `start_i` in idle begins a scan. On the next cycle `busy_o` is 1, `done_o` is 0, and `err_flags_o` and `bad_map_o` are cleared. A `start_i` pulse that arrives while busy is ignored.
- R2: Ways are visited in the order 0, 1, 2, 3. Each way first gets a tag read (`rd_data_o`=0) at address `(way<<13)|set_idx_i`. In data mode, four data reads (`rd_data_o`=1) follow, at `(way<<13)|set_idx_i|(k<<3)` for k = 0, 1, 2, 3.
- R3: The state field is tag-high bits 29:25. The permitted codes are 0x00, 0x0F, 0x13, 0x16, 0x19 and 0x1C. Any other code sets `err_flags_o[30]`.
- R4: For a permitted state, tag-low bit 11 must equal the XOR of tag-low bits 39:26, and tag-low bit 10 must equal the XOR of bits 25:13. A mismatch sets `err_flags_o[29]`. Parity is not checked when the state code is not permitted.
- R5: Check bit i is the XOR-reduction of (data & Mi), where M0 = 0x0738C808099264FF and each Mi is M0 rotated left by 8*i bits. The recomputed code is compared with the low byte of the data-high word. A syndrome of weight one sets `err_flags_o[28]`.
- R6: A syndrome of weight two or more sets `err_flags_o[27]`.
- R7: A failed doubleword at offset k of way w sets `bad_map_o[4*w + 3 - k]`.
- R8: `lru_o` takes tag-high bits 21:14 from the way-0 tag read and holds that value afterwards.
- R9: In tag-only mode no data read is issued, and the data flags and `bad_map_o` stay 0. Counting the edge that samples `start_i`, `done_o` rises on the 6th rising edge in tag-only mode and on the 22nd in data mode.
- R10: Flags from all ways accumulate. They hold until the next start, and only bits 30:27 can ever be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scan (sampled in idle) |
| chk_data_i | input | 1 | Also check data doublewords |
| set_idx_i | input | 13 | Set index, offset bits zero |
| rd_req_o | output | 1 | Array read this cycle |
| rd_data_o | output | 1 | 0 = tag read, 1 = data read |
| rd_addr_o | output | 15 | Array read address |
| rsp_hi_i | input | 32 | Tag-high word or data check byte |
| rsp_lo_i | input | 64 | Tag-low word or data doubleword |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan finished, results valid |
| err_flags_o | output | 32 | Accumulated error flags |
| bad_map_o | output | 16 | Failed doubleword map |
| lru_o | output | 8 | LRU byte of the set |

## Verification
A fault in the way/offset sequencer shows up at once at the ports. Either the read address stream departs from the expected order, or `done_o` rises on the wrong edge, so every scan compares both. A wrong ECC mask or a wrong syndrome grade appears only when a faulty doubleword is read, one cycle after that beat. Each mode is therefore driven with check-byte flips of weight one and higher, at differing ways and offsets. A stale flag register shows only when a clean scan follows a faulty one, so the vector order alternates the two.

// File: rtl/dcache_set_scrub.sv
`timescale 1ns/1ps
module dcache_set_scrub #(
  parameter int WAYS   = 4,
  parameter int BEATS  = 4,
  parameter int WAY_SH = 13
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  input  logic                              chk_data_i,
  input  logic [WAY_SH-1:0]                 set_idx_i,
  output logic                              rd_req_o,
  output logic                              rd_data_o,
  output logic [WAY_SH+$clog2(WAYS)-1:0]    rd_addr_o,
  input  logic [31:0]                       rsp_hi_i,
  input  logic [63:0]                       rsp_lo_i,
  output logic                              busy_o,
  output logic                              done_o,
  output logic [31:0]                       err_flags_o,
  output logic [WAYS*BEATS-1:0]             bad_map_o,
  output logic [7:0]                        lru_o
);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int OFF_W  = $clog2(BEATS);
  localparam int ADDR_W = WAY_SH + WAY_W;
  localparam int MAP_W  = WAYS * BEATS;
  localparam logic [63:0] MASK0 = 64'h0738C808099264FF;
  localparam logic [31:0] FLAG_MASK = 32'h7800_0000;

  typedef enum logic [1:0] {S_IDLE, S_TAG, S_DAT, S_FIN} st_t;

  st_t               st_q;
  logic [WAY_W-1:0]  way_q, bway_q;
  logic [OFF_W-1:0]  off_q, boff_q;
  logic [WAY_SH-1:0] idx_q;
  logic              data_q, done_q, beat_v_q;
  logic [7:0]        ecc_q, code_q, lru_q;
  logic [31:0]       flags_q;
  logic [MAP_W-1:0]  map_q;
  logic [7:0]        ecc_c, syn;
  logic [4:0]        t_state;
  logic              t_legal, ptag_bad, last_way, last_off;
  logic              unused_bits;

  assign t_state  = rsp_hi_i[29:25];
  assign t_legal  = (t_state == 5'h00) || (t_state == 5'h0F) || (t_state == 5'h13) ||
                    (t_state == 5'h16) || (t_state == 5'h19) || (t_state == 5'h1C);
  assign ptag_bad = (rsp_lo_i[11] ^ (^rsp_lo_i[39:26])) | (rsp_lo_i[10] ^ (^rsp_lo_i[25:13]));
  assign unused_bits = ^{rsp_hi_i[31:30], rsp_hi_i[24:22], rsp_hi_i[13:8]};

  for (genvar g = 0; g < 8; g++) begin : g_chk
    localparam logic [63:0] M = (MASK0 << (8*g)) | (MASK0 >> ((64 - 8*g) % 64));
    assign ecc_c[g] = ^(rsp_lo_i & M);
  end

  assign syn      = ecc_q ^ code_q;
  assign last_way = (way_q == WAY_W'(WAYS-1));
  assign last_off = (off_q == OFF_W'(BEATS-1));

  assign rd_req_o    = (st_q == S_TAG) || (st_q == S_DAT);
  assign rd_data_o   = (st_q == S_DAT);
  assign rd_addr_o   = {way_q, idx_q} | (rd_data_o ? (ADDR_W'(off_q) << 3) : '0);
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = done_q;
  assign err_flags_o = flags_q;
  assign bad_map_o   = map_q;
  assign lru_o       = lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      way_q    <= '0;
      off_q    <= '0;
      bway_q   <= '0;
      boff_q   <= '0;
      idx_q    <= '0;
      data_q   <= 1'b0;
      done_q   <= 1'b0;
      beat_v_q <= 1'b0;
      ecc_q    <= '0;
      code_q   <= '0;
      lru_q    <= '0;
      flags_q  <= '0;
      map_q    <= '0;
    end else begin
      beat_v_q <= 1'b0;
      if (beat_v_q && (syn != 8'h00)) begin
        if ($countones(syn) == 1) flags_q[28] <= 1'b1;
        else                      flags_q[27] <= 1'b1;
        map_q[{bway_q, ~boff_q}] <= 1'b1;
      end
      case (st_q)
        S_IDLE: if (start_i) begin
          st_q    <= S_TAG;
          flags_q <= '0;
          map_q   <= '0;
          done_q  <= 1'b0;
          idx_q   <= set_idx_i;
          data_q  <= chk_data_i;
          way_q   <= '0;
          off_q   <= '0;
        end
        S_TAG: begin
          if (!t_legal)      flags_q[30] <= 1'b1;
          else if (ptag_bad) flags_q[29] <= 1'b1;
          if (way_q == '0) lru_q <= rsp_hi_i[21:14];
          off_q <= '0;
          if (data_q)        st_q <= S_DAT;
          else if (last_way) st_q <= S_FIN;
          else               way_q <= way_q + 1'b1;
        end
        S_DAT: begin
          beat_v_q <= 1'b1;
          ecc_q    <= ecc_c;
          code_q   <= rsp_hi_i[7:0];
          bway_q   <= way_q;
          boff_q   <= off_q;
          if (!last_off)     off_q <= off_q + 1'b1;
          else if (last_way) st_q  <= S_FIN;
          else begin
            way_q <= way_q + 1'b1;
            st_q  <= S_TAG;
          end
        end
        default: begin
          st_q   <= S_IDLE;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  // R1
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && start_i) |=> (busy_o && !done_o && flags_q == '0 && map_q == '0));
  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R2
  tag_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_data_o) |-> (rd_addr_o[WAY_SH-1:0] == idx_q));
  // R7
  map_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|map_q) |-> (flags_q[28] || flags_q[27]));
  // R8
  lru_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && !start_i) |=> $stable(lru_q));
  // R9
  tag_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !data_q) |-> !rd_data_o);
  // R10
  flag_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & ~FLAG_MASK) == '0);
  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && !start_i) |=> $stable(flags_q) && $stable(map_q));
endmodule

// File: tb/dcache_set_scrub_tb.sv
`timescale 1ns/1ps
module dcache_set_scrub_tb_top;
  localparam int CLK_NS = 10;
  localparam logic [63:0] M0 = 64'h0738C808099264FF;
  localparam logic [12:0] IDX = 13'h0A60;
  // {data, way[1:0], off[1:0], state[4:0], ptag_bad, flip[7:0]}
  localparam logic [18:0] VEC [8] = '{
    {1'b1, 2'd0, 2'd0, 5'h0F, 1'b0, 8'h00},
    {1'b1, 2'd1, 2'd2, 5'h13, 1'b0, 8'h04},
    {1'b1, 2'd3, 2'd0, 5'h19, 1'b0, 8'h81},
    {1'b0, 2'd2, 2'd1, 5'h05, 1'b0, 8'h00},
    {1'b0, 2'd0, 2'd0, 5'h1C, 1'b1, 8'h00},
    {1'b1, 2'd2, 2'd3, 5'h16, 1'b1, 8'h07},
    {1'b0, 2'd1, 2'd1, 5'h00, 1'b0, 8'h10},
    {1'b1, 2'd0, 2'd3, 5'h1F, 1'b1, 8'h02}
  };

  logic clk = 0, rst_n = 0, start = 0, chk_data = 0;
  logic rd_req, rd_data, busy, done;
  logic [14:0] rd_addr;
  logic [31:0] rsp_hi, flags;
  logic [63:0] rsp_lo;
  logic [15:0] bmap;
  logic [7:0]  lru;
  logic [31:0] thi [4];
  logic [63:0] tlo [4];
  logic [7:0]  dhi [4][4];
  logic [63:0] dlo [4][4];
  logic [15:0] req_log [32];
  int nlog = 0, n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  dcache_set_scrub dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .chk_data_i(chk_data), .set_idx_i(IDX),
    .rd_req_o(rd_req), .rd_data_o(rd_data), .rd_addr_o(rd_addr),
    .rsp_hi_i(rsp_hi), .rsp_lo_i(rsp_lo), .busy_o(busy), .done_o(done),
    .err_flags_o(flags), .bad_map_o(bmap), .lru_o(lru));

  always_comb begin
    if (rd_data) begin
      rsp_hi = {24'h0, dhi[rd_addr[14:13]][rd_addr[4:3]]};
      rsp_lo = dlo[rd_addr[14:13]][rd_addr[4:3]];
    end else begin
      rsp_hi = thi[rd_addr[14:13]];
      rsp_lo = tlo[rd_addr[14:13]];
    end
  end

  always @(negedge clk) if (rd_req) begin
    if (nlog < 32) req_log[nlog] = {rd_data, rd_addr};
    nlog++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_ecc(input logic [63:0] d);
    logic [7:0] p = '0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 64; j++)
        if (d[j] && M0[(j - 8*i + 64) % 64]) p[i] = ~p[i];
    return p;
  endfunction

  function automatic bit ok_state(input logic [4:0] s);
    return s == 5'h00 || s == 5'h0F || s == 5'h13 || s == 5'h16 || s == 5'h19 || s == 5'h1C;
  endfunction

  task automatic build(input int seed, input logic [1:0] tw, input logic [1:0] to,
                       input logic [4:0] st, input logic pbad, input logic [7:0] flip);
    for (int w = 0; w < 4; w++) begin
      logic [63:0] lo = {seed[15:0], 16'h5A3C ^ 16'(w), seed[7:0], 8'(w*37), 16'hC0DE} ^ 64'(seed * 7919);
      lo[11] = ^lo[39:26];
      lo[10] = ^lo[25:13];
      if (w == int'(tw) && pbad) lo[11] = ~lo[11];
      tlo[w] = lo;
      thi[w] = '0;
      thi[w][29:25] = (w == int'(tw)) ? st : 5'h0F;
      thi[w][21:14] = 8'hE4 ^ 8'(seed * 3 + w * 85);
      for (int k = 0; k < 4; k++) begin
        dlo[w][k] = {lo[31:0] ^ 32'(k * 12345), lo[63:32] + 32'(w)};
        dhi[w][k] = ref_ecc(dlo[w][k]) ^ ((w == int'(tw) && k == int'(to)) ? flip : 8'h00);
      end
    end
  endtask

  task automatic run_scan(input logic dm, input int poke, output int cyc);
    @(negedge clk);
    start = 1; chk_data = dm; nlog = 0;
    @(posedge clk); cyc = 1;
    @(negedge clk); start = 0;
    while (!done && cyc < 100) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      start = (cyc == poke);
      chk_data = (cyc == poke) ? ~dm : dm;
    end
    start = 0;
    if (cyc >= 100) chk("watchdog scan hang", 1, 0);
  endtask

  task automatic chk_log(input logic dm, input string req);
    int n = 0;
    for (int w = 0; w < 4; w++) begin
      chk(req, req_log[n], {1'b0, 2'(w), IDX}); n++;
      if (dm) for (int k = 0; k < 4; k++) begin
        chk(req, req_log[n], {1'b1, 2'(w), IDX | 13'(k << 3)}); n++;
      end
    end
    chk(req, nlog, n);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] ef;
    logic [15:0] em;
    build(1, 0, 0, 5'h0F, 0, 0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R10 reset flags", flags, 0);
    chk("R7 reset map", bmap, 0);
    chk("R8 reset lru", lru, 0);
    rst_n = 1;

    for (int v = 0; v < 8; v++) begin
      logic dm = VEC[v][18];
      logic [1:0] tw = VEC[v][17:16], to = VEC[v][15:14];
      logic [4:0] st = VEC[v][13:9];
      logic pb = VEC[v][8];
      logic [7:0] fl = VEC[v][7:0];
      build(v + 2, tw, to, st, pb, fl);
      ef = '0; em = '0;
      if (!ok_state(st)) ef[30] = 1;        // R3
      else if (pb) ef[29] = 1;              // R4
      if (dm && fl != 0) begin
        if ($countones(fl) == 1) ef[28] = 1; // R5
        else ef[27] = 1;                     // R6
        em[4*tw + 3 - to] = 1;               // R7
      end
      run_scan(dm, 0, cyc);
      chk("R9 cycles", cyc, dm ? 22 : 6);
      chk("R3 R4 R5 R6 flags", flags, ef);
      chk("R7 map", bmap, em);
      chk("R8 lru", lru, thi[0][21:14]);
      chk_log(dm, "R2 order");
    end

    // R4: illegal state suppresses parity; R10: accumulate across ways
    build(20, 1, 0, 5'h1F, 1, 0);
    dhi[3][1] = dhi[3][1] ^ 8'h40;
    tlo[2][10] = ~tlo[2][10];
    run_scan(1, 0, cyc);
    chk("R10 accumulate", flags, 32'h7000_0000);
    chk("R7 map way3 off1", bmap, 16'h4000);

    // R10 hold after done; R1 start ignored while busy
    repeat (4) @(negedge clk);
    chk("R10 hold flags", flags, 32'h7000_0000);
    chk("R1 done held", done, 1);
    build(21, 2, 2, 5'h0F, 0, 8'h30);
    run_scan(1, 7, cyc);
    chk("R1 busy start ignored cycles", cyc, 22);
    chk("R1 busy start ignored flags", flags, 32'h0800_0000);
    chk("R7 map way2 off2", bmap, 16'h0200);
    chk_log(1, "R2 order busy start");

    // R9 tag-only mode ignores corrupt data
    build(22, 3, 3, 5'h0F, 0, 8'hFF);
    run_scan(0, 0, cyc);
    chk("R9 tag-only flags", flags, 0);
    chk("R9 tag-only map", bmap, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule